// File: doc/BRIEF.md
# VLAN-aware MAC learning forwarder

This block makes the forwarding decision for each parsed frame in a small Ethernet switch. The switch has five physical ports, five plugin destinations and one control-processor destination. A frame descriptor carries the VLAN number, the source and destination MAC addresses and the ingress port. Two lookups run on it in the same cycle, both against one shared ternary table of 32 entries.

The destination lookup returns an 11-bit copy vector. Every VLAN owns a low-priority default entry that compares the VLAN field only and lists the VLAN's member ports. Unknown unicast, broadcast and multicast destinations all resolve to that entry. The ingress port is removed from the vector, and addresses and VLAN pass through unchanged. Loop freedom depends only on how those member vectors are configured. The block runs no tree protocol of its own.

The source lookup checks whether the sender is already bound to its ingress port. When there is no binding, or the binding names another port, a learning notification is queued for the control processor, which then rewrites the table. Notifications that find the queue full are dropped and counted, so forwarding never stalls.

Top module: `l2_fwd_engine`

## Requirements
- R1: Each descriptor accepted with `frm_valid` high at a clock edge produces exactly one result, with `fwd_valid` high after the second following edge, in input order.
- R2: A table key is {type bit 60 (1 = destination entry, 0 = source entry), VLAN [59:48], MAC [47:0]}. Mask bits set to 1 are compared. The type bit is always compared. Among valid matching entries, the lowest index wins. A destination winner supplies the copy vector from result bits [10:0] (bits 0-4 physical ports, 5-9 plugins, 10 control processor) and `fwd_plugin_sel` from bit 11. `fwd_hit` is 1. `fwd_flood` is 0 when the winner compares any MAC bit.
- R3: A destination MAC with bit 40 set (group address, broadcast included) can match only entries that compare no MAC bit, even if a more specific entry matches. A winner that compares no MAC bit, which is also the fallback for unknown unicast, sets `fwd_flood` to 1.
- R4: When no entry matches the destination key, `fwd_hit`, `fwd_flood` and `fwd_plugin_sel` are 0 and `fwd_vec` is all zero.
- R5: When the ingress port is 0 to 4, that bit of `fwd_vec` is cleared. All other bits are kept.
- R6: `fwd_vlan`, `fwd_smac`, `fwd_dmac` and `fwd_port` equal the descriptor's fields unchanged.
- R7: The source key is {0, VLAN, source MAC}, and a source result holds the bound port in bits [24:22] and a destination-entry index in bits [21:0]. A miss queues a notification with `lrn_moved`=0 and index 0. A hit whose port differs from the ingress port queues one with `lrn_moved`=1 and the stored index. A hit on the same port queues nothing.
- R8: Notifications are delivered in arrival order through `lrn_valid`/`lrn_ready`. While not accepted, the head and its fields hold steady.
- R9: A notification arriving while the queue holds LRN_DEPTH (4) entries is discarded, and `lrn_drops` increments by one, saturating.
- R10: A table write replaces valid bit, key, mask and result of one entry at a single edge. A write with valid 0 removes the entry from both lookups.
- R11: After reset, `fwd_valid` and `lrn_valid` are 0, `lrn_drops` is 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 5 | Entry index to write |
| tbl_wr_valid | input | 1 | Valid bit of the written entry |
| tbl_wr_key | input | 61 | Entry key {type, VLAN, MAC} |
| tbl_wr_mask | input | 61 | Entry compare mask (1 = compare) |
| tbl_wr_res | input | 32 | Entry result word |
| frm_valid | input | 1 | Descriptor present |
| frm_vlan | input | 12 | Frame VLAN |
| frm_smac | input | 48 | Source MAC |
| frm_dmac | input | 48 | Destination MAC |
| frm_port | input | 3 | Ingress port |
| fwd_valid | output | 1 | Decision present |
| fwd_hit | output | 1 | Destination lookup matched |
| fwd_flood | output | 1 | Winner was a VLAN-wide entry |
| fwd_plugin_sel | output | 1 | Plugin/port selection bit |
| fwd_vec | output | 11 | Copy vector |
| fwd_vlan | output | 12 | VLAN passed through |
| fwd_smac | output | 48 | Source MAC passed through |
| fwd_dmac | output | 48 | Destination MAC passed through |
| fwd_port | output | 3 | Ingress port passed through |
| lrn_valid | output | 1 | Notification at queue head |
| lrn_ready | input | 1 | Control processor accepts head |
| lrn_vlan | output | 12 | Notification VLAN |
| lrn_mac | output | 48 | Notification source MAC |
| lrn_port | output | 3 | Port the MAC was seen on |
| lrn_didx | output | 22 | Index from the stale binding, 0 on a miss |
| lrn_moved | output | 1 | 1 = port mismatch, 0 = miss |
| lrn_drops | output | 8 | Saturating count of discarded notifications |

## Verification
Destinations are tried as exact unicast hits, as two entries with the same key at different indices, and as unknown unicast, broadcast and multicast addresses. The multicast case uses an address that also has an exact entry. Together these separate priority selection, fallback to the VLAN entry, and the group-address bypass. Ingress ports that appear in the winning vector show whether the reflection clear works. A VLAN with no entries at all separates a true miss from a flood. Source addresses are tried bound to the same port, bound to another port, unbound, and present only as a destination entry, which shows the type bit keeping the two lookups apart. Holding the notification queue while six misses arrive exposes ordering, head stability and the drop count.

// File: rtl/l2fwd_pkg.sv
package l2fwd_pkg;
  localparam int VLAN_W   = 12;
  localparam int MAC_W    = 48;
  localparam int PORT_W   = 3;
  localparam int N_PHY    = 5;
  localparam int N_PLUG   = 5;
  localparam int VEC_W    = N_PHY + N_PLUG + 1;
  localparam int DIDX_W   = 22;
  localparam int KEY_W    = 1 + VLAN_W + MAC_W;
  localparam int RES_W    = 32;
  localparam int SEL_BIT  = VEC_W;          // plugin/port select in a destination result
  localparam int SPORT_LSB = DIDX_W;        // bound port in a source result
  localparam int GRP_BIT  = MAC_W - 8;      // group bit of the first octet

  typedef struct packed {
    logic [VLAN_W-1:0] vlan;
    logic [MAC_W-1:0]  mac;
    logic [PORT_W-1:0] port;
    logic [DIDX_W-1:0] didx;
    logic              moved;
  } lrn_t;
endpackage

// File: rtl/l2fwd_rst_sync.sv
module l2fwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/l2fwd_tcam.sv
module l2fwd_tcam
  import l2fwd_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int N_LK  = 2,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_valid,
  input  logic [KEY_W-1:0]            wr_key,
  input  logic [KEY_W-1:0]            wr_mask,
  input  logic [RES_W-1:0]            wr_res,
  input  logic [N_LK-1:0][KEY_W-1:0]  lk_key,
  input  logic [N_LK-1:0]             lk_grp,
  output logic [N_LK-1:0]             lk_hit,
  output logic [N_LK-1:0][RES_W-1:0]  lk_res,
  output logic [N_LK-1:0]             lk_wide
);
  localparam logic [KEY_W-1:0] TYPE_MASK = {1'b1, {(KEY_W-1){1'b0}}};

  logic [N_ENT-1:0] ent_vld_q, ent_vld_n;
  logic [KEY_W-1:0] ent_key_q  [N_ENT];
  logic [KEY_W-1:0] ent_mask_q [N_ENT];
  logic [RES_W-1:0] ent_res_q  [N_ENT];

  // valid bits: next state
  always_comb begin
    ent_vld_n = ent_vld_q;
    if (wr_en) ent_vld_n[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_vld_q <= '0;
    else        ent_vld_q <= ent_vld_n;
  end

  // entry contents: no reset, gated by the valid bit
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key_q[wr_idx]  <= wr_key;
      ent_mask_q[wr_idx] <= wr_mask;
      ent_res_q[wr_idx]  <= wr_res;
    end
  end

  genvar p, e;
  generate
    for (p = 0; p < N_LK; p++) begin : g_lk
      logic [N_ENT-1:0] match;
      logic             hit_c;
      logic [IDX_W-1:0] win_c;

      for (e = 0; e < N_ENT; e++) begin : g_ent
        logic key_eq;
        logic vlan_only;
        assign key_eq    = ((lk_key[p] ^ ent_key_q[e]) & (ent_mask_q[e] | TYPE_MASK)) == '0;
        assign vlan_only = ent_mask_q[e][MAC_W-1:0] == '0;
        assign match[e]  = ent_vld_q[e] & key_eq & (~lk_grp[p] | vlan_only);
      end

      // lowest index wins: scan downwards, last hit kept
      always_comb begin
        hit_c = 1'b0;
        win_c = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
          if (match[i]) begin
            hit_c = 1'b1;
            win_c = IDX_W'(i);
          end
        end
      end

      assign lk_hit[p]  = hit_c;
      assign lk_res[p]  = ent_res_q[win_c];
      assign lk_wide[p] = ent_mask_q[win_c][MAC_W-1:0] == '0;
    end
  endgenerate
endmodule

// File: rtl/l2fwd_lrn_fifo.sv
module l2fwd_lrn_fifo
  import l2fwd_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  lrn_t              push_data,
  output logic              out_valid,
  input  logic              out_ready,
  output lrn_t              out_data,
  output logic [DROP_W-1:0] drops
);
  lrn_t              mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DROP_W-1:0] drops_q, drops_n;
  logic              do_push, do_pop, full;

  always_comb begin
    full    = cnt_q == CNT_W'(DEPTH);
    do_pop  = (cnt_q != '0) & out_ready;
    do_push = push & ~full;
    wr_n    = wr_q;
    rd_n    = rd_q;
    if (do_push) wr_n = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_n   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    drops_n = drops_q;
    if (push && full && drops_q != '1) drops_n = drops_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      drops_q <= '0;
    end else begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      cnt_q   <= cnt_n;
      drops_q <= drops_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign out_valid = cnt_q != '0;
  assign out_data  = mem_q[rd_q];
  assign drops     = drops_q;
endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine
  import l2fwd_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int LRN_DEPTH = 4,
  parameter int DROP_W    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic               tbl_wr_valid,
  input  logic [KEY_W-1:0]   tbl_wr_key,
  input  logic [KEY_W-1:0]   tbl_wr_mask,
  input  logic [RES_W-1:0]   tbl_wr_res,
  input  logic               frm_valid,
  input  logic [VLAN_W-1:0]  frm_vlan,
  input  logic [MAC_W-1:0]   frm_smac,
  input  logic [MAC_W-1:0]   frm_dmac,
  input  logic [PORT_W-1:0]  frm_port,
  output logic               fwd_valid,
  output logic               fwd_hit,
  output logic               fwd_flood,
  output logic               fwd_plugin_sel,
  output logic [VEC_W-1:0]   fwd_vec,
  output logic [VLAN_W-1:0]  fwd_vlan,
  output logic [MAC_W-1:0]   fwd_smac,
  output logic [MAC_W-1:0]   fwd_dmac,
  output logic [PORT_W-1:0]  fwd_port,
  output logic               lrn_valid,
  input  logic               lrn_ready,
  output logic [VLAN_W-1:0]  lrn_vlan,
  output logic [MAC_W-1:0]   lrn_mac,
  output logic [PORT_W-1:0]  lrn_port,
  output logic [DIDX_W-1:0]  lrn_didx,
  output logic               lrn_moved,
  output logic [DROP_W-1:0]  lrn_drops
);
  localparam int LK_SRC = 0;
  localparam int LK_DST = 1;

  logic rst_sync_n;

  l2fwd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // ---------------- stage 1: descriptor capture ----------------
  logic              s1_vld_q;
  logic [VLAN_W-1:0] s1_vlan_q;
  logic [MAC_W-1:0]  s1_smac_q, s1_dmac_q;
  logic [PORT_W-1:0] s1_port_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_vld_q <= 1'b0;
    else             s1_vld_q <= frm_valid;
  end

  always_ff @(posedge clk) begin
    if (frm_valid) begin
      s1_vlan_q <= frm_vlan;
      s1_smac_q <= frm_smac;
      s1_dmac_q <= frm_dmac;
      s1_port_q <= frm_port;
    end
  end

  // ---------------- shared table, two lookups ----------------
  logic [1:0][KEY_W-1:0] lk_key;
  logic [1:0]            lk_grp, lk_hit, lk_wide;
  logic [1:0][RES_W-1:0] lk_res;

  assign lk_key[LK_SRC] = {1'b0, s1_vlan_q, s1_smac_q};
  assign lk_grp[LK_SRC] = 1'b0;
  assign lk_key[LK_DST] = {1'b1, s1_vlan_q, s1_dmac_q};
  assign lk_grp[LK_DST] = s1_dmac_q[GRP_BIT];

  l2fwd_tcam #(.N_ENT(N_ENTRIES), .N_LK(2)) u_tcam (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_valid (tbl_wr_valid),
    .wr_key   (tbl_wr_key),
    .wr_mask  (tbl_wr_mask),
    .wr_res   (tbl_wr_res),
    .lk_key   (lk_key),
    .lk_grp   (lk_grp),
    .lk_hit   (lk_hit),
    .lk_res   (lk_res),
    .lk_wide  (lk_wide)
  );

  // ---------------- decision: forwarding ----------------
  logic [VEC_W-1:0] vec_c;
  logic             sel_c, flood_c;

  always_comb begin
    vec_c   = lk_hit[LK_DST] ? lk_res[LK_DST][VEC_W-1:0] : '0;
    sel_c   = lk_hit[LK_DST] & lk_res[LK_DST][SEL_BIT];
    flood_c = lk_hit[LK_DST] & lk_wide[LK_DST];
    for (int k = 0; k < N_PHY; k++) begin
      if (s1_port_q == PORT_W'(k)) vec_c[k] = 1'b0;
    end
  end

  // ---------------- decision: learning ----------------
  logic              notify_c;
  lrn_t              notif_c;
  logic [PORT_W-1:0] bound_port;

  assign bound_port = lk_res[LK_SRC][SPORT_LSB +: PORT_W];

  always_comb begin
    notify_c      = s1_vld_q & (~lk_hit[LK_SRC] | (bound_port != s1_port_q));
    notif_c.vlan  = s1_vlan_q;
    notif_c.mac   = s1_smac_q;
    notif_c.port  = s1_port_q;
    notif_c.moved = lk_hit[LK_SRC];
    notif_c.didx  = lk_hit[LK_SRC] ? lk_res[LK_SRC][DIDX_W-1:0] : '0;
  end

  lrn_t lrn_head;

  l2fwd_lrn_fifo #(.DEPTH(LRN_DEPTH), .DROP_W(DROP_W)) u_lrn (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (notify_c),
    .push_data (notif_c),
    .out_valid (lrn_valid),
    .out_ready (lrn_ready),
    .out_data  (lrn_head),
    .drops     (lrn_drops)
  );

  assign lrn_vlan  = lrn_head.vlan;
  assign lrn_mac   = lrn_head.mac;
  assign lrn_port  = lrn_head.port;
  assign lrn_didx  = lrn_head.didx;
  assign lrn_moved = lrn_head.moved;

  // ---------------- stage 2: result register ----------------
  logic fwd_vld_q, fwd_vld_n;

  assign fwd_vld_n = s1_vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fwd_vld_q <= 1'b0;
    else             fwd_vld_q <= fwd_vld_n;
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      fwd_hit        <= lk_hit[LK_DST];
      fwd_flood      <= flood_c;
      fwd_plugin_sel <= sel_c;
      fwd_vec        <= vec_c;
      fwd_vlan       <= s1_vlan_q;
      fwd_smac       <= s1_smac_q;
      fwd_dmac       <= s1_dmac_q;
      fwd_port       <= s1_port_q;
    end
  end

  assign fwd_valid = fwd_vld_q;
endmodule

// File: rtl/l2fwd_chk.sv
module l2fwd_chk
  import l2fwd_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic [MAC_W-1:0]  frm_smac,
  input logic [MAC_W-1:0]  frm_dmac,
  input logic              fwd_valid,
  input logic              fwd_hit,
  input logic              fwd_flood,
  input logic              fwd_plugin_sel,
  input logic [VEC_W-1:0]  fwd_vec,
  input logic [MAC_W-1:0]  fwd_smac,
  input logic [MAC_W-1:0]  fwd_dmac,
  input logic [PORT_W-1:0] fwd_port,
  input logic              lrn_valid,
  input logic              lrn_ready,
  input logic [MAC_W-1:0]  lrn_mac,
  input logic [DIDX_W-1:0] lrn_didx,
  input logic [DROP_W-1:0] lrn_drops
);
  AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ##2 fwd_valid); // R1

  AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ##2 (fwd_smac == $past(frm_smac, 2) && fwd_dmac == $past(frm_dmac, 2))); // R6

  AST_NO_REFLECT: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_port < PORT_W'(N_PHY)) |-> !fwd_vec[fwd_port]); // R5

  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_hit) |-> (fwd_vec == '0 && !fwd_flood && !fwd_plugin_sel)); // R4

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lrn_valid && !lrn_ready) |=> (lrn_valid && $stable(lrn_mac) && $stable(lrn_didx))); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrn_drops) |-> (lrn_drops == $past(lrn_drops) + 1'b1)); // R9

  AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrn_drops) |-> $past(lrn_valid)); // R9
endmodule

bind l2_fwd_engine l2fwd_chk #(.DROP_W(DROP_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .frm_valid      (frm_valid),
  .frm_smac       (frm_smac),
  .frm_dmac       (frm_dmac),
  .fwd_valid      (fwd_valid),
  .fwd_hit        (fwd_hit),
  .fwd_flood      (fwd_flood),
  .fwd_plugin_sel (fwd_plugin_sel),
  .fwd_vec        (fwd_vec),
  .fwd_smac       (fwd_smac),
  .fwd_dmac       (fwd_dmac),
  .fwd_port       (fwd_port),
  .lrn_valid      (lrn_valid),
  .lrn_ready      (lrn_ready),
  .lrn_mac        (lrn_mac),
  .lrn_didx       (lrn_didx),
  .lrn_drops      (lrn_drops)
);

// File: tb/tb_l2_fwd_engine.sv
module tb_l2_fwd_engine;
  import l2fwd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tbl_wr_en, tbl_wr_valid;
  logic [4:0]        tbl_wr_idx;
  logic [KEY_W-1:0]  tbl_wr_key, tbl_wr_mask;
  logic [RES_W-1:0]  tbl_wr_res;
  logic              frm_valid;
  logic [VLAN_W-1:0] frm_vlan;
  logic [MAC_W-1:0]  frm_smac, frm_dmac;
  logic [PORT_W-1:0] frm_port;
  logic              fwd_valid, fwd_hit, fwd_flood, fwd_plugin_sel;
  logic [VEC_W-1:0]  fwd_vec;
  logic [VLAN_W-1:0] fwd_vlan;
  logic [MAC_W-1:0]  fwd_smac, fwd_dmac;
  logic [PORT_W-1:0] fwd_port;
  logic              lrn_valid, lrn_ready, lrn_moved;
  logic [VLAN_W-1:0] lrn_vlan;
  logic [MAC_W-1:0]  lrn_mac;
  logic [PORT_W-1:0] lrn_port;
  logic [DIDX_W-1:0] lrn_didx;
  logic [7:0]        lrn_drops;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_fwd_engine dut (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference table ----------------
  bit               m_vld  [NE];
  logic [KEY_W-1:0] m_key  [NE];
  logic [KEY_W-1:0] m_mask [NE];
  logic [RES_W-1:0] m_res  [NE];

  localparam logic [KEY_W-1:0] FULL_MASK = '1;
  localparam logic [KEY_W-1:0] VLAN_MASK = {1'b1, 12'hFFF, 48'h0};

  task automatic tbl_write(input int idx, input bit v, input logic [KEY_W-1:0] k,
                           input logic [KEY_W-1:0] m, input logic [RES_W-1:0] r);
    @(posedge clk); #1;
    tbl_wr_en = 1'b1; tbl_wr_idx = 5'(idx); tbl_wr_valid = v;
    tbl_wr_key = k; tbl_wr_mask = m; tbl_wr_res = r;
    m_vld[idx] = v; m_key[idx] = k; m_mask[idx] = m; m_res[idx] = r;
    @(posedge clk); #1;
    tbl_wr_en = 1'b0;
  endtask

  task automatic ref_lookup(input logic [KEY_W-1:0] k, input bit grp,
                            output bit hit, output logic [RES_W-1:0] res, output bit wide);
    hit = 0; res = '0; wide = 0;
    for (int i = 0; i < NE; i++) begin
      logic [KEY_W-1:0] m;
      m = m_mask[i];
      m[KEY_W-1] = 1'b1;
      if (!hit && m_vld[i] && (((k ^ m_key[i]) & m) == '0) &&
          (!grp || m_mask[i][MAC_W-1:0] == '0)) begin
        hit = 1; res = m_res[i]; wide = (m_mask[i][MAC_W-1:0] == '0);
      end
    end
  endtask

  // ---------------- scoreboard queues ----------------
  logic [13:0]  exp_res_q [$];
  logic [110:0] exp_echo_q [$];
  int           exp_cyc_q [$];
  string        exp_tag_q [$];
  logic [85:0]  exp_lrn_q [$];
  bit hold_mode = 0;
  int held = 0;
  int drop_exp = 0;

  task automatic send(input logic [11:0] vlan, input logic [47:0] smac,
                      input logic [47:0] dmac, input logic [2:0] port, input string tag);
    bit h, w, sh, sw;
    logic [RES_W-1:0] r, sr;
    logic [VEC_W-1:0] v;
    logic sel, fl;
    ref_lookup({1'b1, vlan, dmac}, dmac[40], h, r, w);
    v = h ? r[10:0] : '0;
    if (port < 3'd5) v[port] = 1'b0;
    sel = h & r[11];
    fl = h & w;
    exp_res_q.push_back({h, fl, sel, v});
    exp_echo_q.push_back({vlan, smac, dmac, port});
    exp_tag_q.push_back(tag);
    ref_lookup({1'b0, vlan, smac}, 1'b0, sh, sr, sw);
    if (!sh || sr[24:22] != port) begin
      if (hold_mode && held >= 4) drop_exp++;
      else exp_lrn_q.push_back({vlan, smac, port, sh ? sr[21:0] : 22'h0, sh});
      if (hold_mode) held++;
    end
    frm_vlan = vlan; frm_smac = smac; frm_dmac = dmac; frm_port = port;
    frm_valid = 1'b1;
    exp_cyc_q.push_back(cyc + 2);
    @(posedge clk); #1;
    frm_valid = 1'b0;
  endtask

  // ---------------- monitors ----------------
  always @(negedge clk) begin
    if (rst_n && fwd_valid) begin
      if (exp_res_q.size() == 0) begin
        chk(0, "R1", "unexpected result", 1, 0);
      end else begin
        logic [13:0] er;
        logic [110:0] ee;
        int ec;
        string t;
        er = exp_res_q.pop_front(); ee = exp_echo_q.pop_front();
        ec = exp_cyc_q.pop_front(); t = exp_tag_q.pop_front();
        chk({fwd_hit, fwd_flood, fwd_plugin_sel, fwd_vec} == er, t, "hit/flood/sel/vec",
            {fwd_hit, fwd_flood, fwd_plugin_sel, fwd_vec}, er);
        chk({fwd_vlan, fwd_smac, fwd_dmac, fwd_port} == ee, "R6", "echo",
            {fwd_vlan, fwd_smac, fwd_dmac, fwd_port}, ee);
        chk(cyc == ec, "R1", "latency", cyc, ec);
      end
    end
    if (rst_n && lrn_valid && lrn_ready) begin
      if (exp_lrn_q.size() == 0) begin
        chk(0, "R7", "unexpected notification", {lrn_vlan, lrn_mac}, 0);
      end else begin
        logic [85:0] el;
        el = exp_lrn_q.pop_front();
        chk({lrn_vlan, lrn_mac, lrn_port, lrn_didx, lrn_moved} == el, "R7", "notification",
            {lrn_vlan, lrn_mac, lrn_port, lrn_didx, lrn_moved}, el);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  localparam logic [47:0] MAC_B  = 48'h0200_0000_00B0;
  localparam logic [47:0] MAC_C  = 48'h0200_0000_00C0;
  localparam logic [47:0] MAC_D  = 48'h0200_0000_00D0;
  localparam logic [47:0] MAC_S1 = 48'h0200_0000_0011;
  localparam logic [47:0] MAC_S2 = 48'h0200_0000_0012;
  localparam logic [47:0] MAC_S3 = 48'h0200_0000_0013;
  localparam logic [47:0] MAC_MC = 48'h0100_5E00_0001;
  localparam logic [47:0] MAC_BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [11:0] VA = 12'h00A, VB = 12'h014, VC = 12'h01E;

  initial begin
    rst_n = 1'b0; tbl_wr_en = 0; tbl_wr_valid = 0; tbl_wr_idx = '0;
    tbl_wr_key = '0; tbl_wr_mask = '0; tbl_wr_res = '0;
    frm_valid = 0; frm_vlan = '0; frm_smac = '0; frm_dmac = '0; frm_port = '0;
    lrn_ready = 1'b1;
    for (int i = 0; i < NE; i++) m_vld[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R11: idle state after reset
    chk(fwd_valid == 0, "R11", "fwd_valid", fwd_valid, 0);
    chk(lrn_valid == 0, "R11", "lrn_valid", lrn_valid, 0);
    chk(lrn_drops == 0, "R11", "lrn_drops", lrn_drops, 0);

    // table setup (R10 atomic writes)
    tbl_write(30, 1, {1'b1, VA, 48'h0}, VLAN_MASK, 32'h0000_040F);
    tbl_write(31, 1, {1'b1, VB, 48'h0}, VLAN_MASK, 32'h0000_0092);
    tbl_write(4,  1, {1'b1, VA, MAC_B}, FULL_MASK, 32'h0000_0008);
    tbl_write(5,  1, {1'b1, VA, MAC_B}, FULL_MASK, 32'h0000_0004);
    tbl_write(6,  1, {1'b1, VA, MAC_C}, FULL_MASK, 32'h0000_0840);
    tbl_write(7,  1, {1'b1, VB, MAC_D}, FULL_MASK, 32'h0000_0002);
    tbl_write(8,  1, {1'b1, VA, MAC_MC}, FULL_MASK, 32'h0000_0010);
    tbl_write(10, 1, {1'b0, VA, MAC_S1}, FULL_MASK, {7'h0, 3'd2, 22'h12345});
    tbl_write(11, 1, {1'b0, VA, MAC_S2}, FULL_MASK, {7'h0, 3'd0, 22'h00077});
    repeat (2) @(posedge clk); #1;

    send(VA, MAC_S1, MAC_B,  3'd2, "R2");  // lower index wins, known source
    send(VA, MAC_S1, MAC_B,  3'd3, "R5");  // ingress bit cleared, source moved (R7)
    send(VA, MAC_S2, MAC_BC, 3'd0, "R3");  // broadcast floods
    send(VA, MAC_S3, MAC_MC, 3'd1, "R3");  // multicast skips exact entry, source miss
    send(VA, MAC_S1, 48'h0200_0000_0999, 3'd4, "R3"); // unknown unicast
    send(VA, MAC_S2, MAC_C,  3'd0, "R2");  // plugin select bit
    send(VB, MAC_S1, MAC_D,  3'd1, "R5");  // only bit is ingress
    send(VC, MAC_S1, MAC_B,  3'd2, "R4");  // VLAN without entries
    send(VB, MAC_S2, MAC_B,  3'd4, "R3");  // other VLAN default
    repeat (8) @(posedge clk); #1;

    tbl_write(4, 0, {1'b1, VA, MAC_B}, FULL_MASK, 32'h0000_0008);
    repeat (2) @(posedge clk); #1;
    send(VA, MAC_B, MAC_B, 3'd0, "R10");   // removed entry, next one wins; dst entry never a source hit
    repeat (8) @(posedge clk); #1;

    // R9 / R8: hold the queue and overfill it
    lrn_ready = 1'b0;
    hold_mode = 1; held = 0; drop_exp = 0;
    for (int i = 0; i < 6; i++) send(VC, 48'h0200_0000_0100 + 48'(i), MAC_B, 3'd1, "R4");
    repeat (6) @(posedge clk); #2;
    chk(lrn_drops == 8'(drop_exp), "R9", "drop count", lrn_drops, drop_exp);
    chk(lrn_valid == 1 && lrn_mac == 48'h0200_0000_0100, "R8", "head held",
        lrn_mac, 48'h0200_0000_0100);
    @(posedge clk); #1;
    hold_mode = 0;
    lrn_ready = 1'b1;
    repeat (12) @(posedge clk); #2;
    chk(exp_lrn_q.size() == 0, "R8", "notifications drained", exp_lrn_q.size(), 0);
    chk(exp_res_q.size() == 0, "R1", "results drained", exp_res_q.size(), 0);
    chk(lrn_valid == 0, "R9", "queue empty after drain", lrn_valid, 0);
    summary();
  end
endmodule